// File: doc/BRIEF.md
# Dual-Direction Byte Substitution Unit with One Shared Field Inverter

This block substitutes one byte at a time, using either the forward AES S-box or its inverse. A select input picks the direction for each byte. Both directions share a single multiplicative-inverse circuit for GF(2^8).

That inverter is pure logic and uses no stored table. It works in three steps:
- a linear change of basis from the AES field into a tower field GF(((2^2)^2)^2);
- the inversion itself, built from GF(2^4) and GF(2^2) multipliers, a squarer and a multiply-by-constant stage;
- a linear map back into the AES field.

The affine transform and its inverse are two separate pieces of logic. Multiplexers steered by the direction select place them around the shared inverter:
- Encryption computes the inverse first and then applies the affine transform.
- Decryption applies the inverse affine transform first and then the inverse.

The tower constants and both basis-change matrices are derived when the design is elaborated. They are not written in as literals.

With `PIPELINED = 1` (the default), a register follows each of the three stages. The unit then accepts a byte every cycle and answers three cycles later. With `PIPELINED = 0` the path is purely combinational.

Top module: `shared_sbox_unit`

## Requirements
- R1: With `in_decrypt` = 0, `out_byte` equals the forward AES S-box of `in_byte` for all 256 inputs (multiplicative inverse in GF(2^8) with polynomial 0x11B, then the affine matrix with constant 0x63).
- R2: With `in_decrypt` = 1, `out_byte` equals the inverse AES S-box of `in_byte` for all 256 inputs (inverse affine matrix with constant 0x05, then the multiplicative inverse).
- R3: The inverse of zero is taken as zero. So encrypt maps 0x00 to 0x63, and decrypt maps 0x63 to 0x00.
- R4: Feeding the encrypt-mode result for any byte x back in decrypt mode returns x.
- R5: With `PIPELINED` = 1, a byte presented with `in_valid` high at a rising edge produces `out_valid` high three rising edges later. Bytes may be presented on consecutive cycles, with the direction changing on any of them.
- R6: `out_valid` is high exactly in the cycles that carry a result of a valid input. While it is low, `out_byte` keeps the last valid result.
- R7: While `rst_n` is low, `out_valid` and `out_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_byte` and `in_decrypt` |
| in_decrypt | input | 1 | 0 selects the forward S-box, 1 the inverse S-box |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Result on `out_byte` is new this cycle |
| out_byte | output | 8 | Substituted byte |

## Verification
A fault in either basis-change matrix or in the tower arithmetic corrupts the inverse for most inputs. It therefore shows up as a wrong `out_byte` within three cycles of the first affected input during the full sweeps.

A direction bit that travels out of step with its byte only shows when the mode changes between adjacent bytes. The alternating-mode stream exercises this.

A stuck stage enable shows as a stale `out_byte`, or as an `out_valid` that is wrong relative to the bubbles in the input stream. The per-cycle model compares both outputs on every cycle.

// File: rtl/sbox_field_pkg.sv
package sbox_field_pkg;

  // GF(2^2): basis {z,1}, z^2 = z + 1
  function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
    gf4_mul = {(a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]),
               (a[1] & b[1]) ^ (a[0] & b[0])};
  endfunction

  function automatic logic [1:0] gf4_sq(input logic [1:0] a);
    gf4_sq = {a[1], a[1] ^ a[0]};
  endfunction

  // multiply by phi = z
  function automatic logic [1:0] gf4_phi(input logic [1:0] a);
    gf4_phi = {a[1] ^ a[0], a[1]};
  endfunction

  // GF(2^4) over GF(2^2): w^2 = w + phi
  function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] hh, ll, xx;
    hh = gf4_mul(a[3:2], b[3:2]);
    ll = gf4_mul(a[1:0], b[1:0]);
    xx = gf4_mul(a[3:2] ^ a[1:0], b[3:2] ^ b[1:0]);
    gf16_mul = {xx ^ ll, gf4_phi(hh) ^ ll};
  endfunction

  function automatic logic [3:0] gf16_sq(input logic [3:0] a);
    gf16_sq = {gf4_sq(a[3:2]), gf4_phi(gf4_sq(a[3:2])) ^ gf4_sq(a[1:0])};
  endfunction

  function automatic logic [3:0] gf16_inv(input logic [3:0] a);
    logic [1:0] d, di;
    d  = gf4_phi(gf4_sq(a[3:2])) ^ gf4_mul(a[3:2], a[1:0]) ^ gf4_sq(a[1:0]);
    di = gf4_sq(d);
    gf16_inv = {gf4_mul(a[3:2], di), gf4_mul(a[3:2] ^ a[1:0], di)};
  endfunction

  // smallest lambda making Y^2 + Y + lambda irreducible over GF(2^4)
  function automatic logic [3:0] find_lambda();
    logic found, hit;
    found = 1'b0;
    find_lambda = 4'h0;
    for (int l = 1; l < 16; l++) begin
      hit = 1'b0;
      for (int t = 0; t < 16; t++)
        if ((gf16_sq(4'(t)) ^ 4'(t)) == 4'(l)) hit = 1'b1;
      if (!hit && !found) begin
        found = 1'b1;
        find_lambda = 4'(l);
      end
    end
  endfunction

  localparam logic [3:0] LAMBDA = find_lambda();

  function automatic logic [3:0] gf16_lambda(input logic [3:0] a);
    gf16_lambda = gf16_mul(a, LAMBDA);
  endfunction

  // GF((2^4)^2): Y^2 = Y + lambda, byte = {high, low}
  function automatic logic [7:0] tower_mul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh, ll, xx;
    hh = gf16_mul(a[7:4], b[7:4]);
    ll = gf16_mul(a[3:0], b[3:0]);
    xx = gf16_mul(a[7:4] ^ a[3:0], b[7:4] ^ b[3:0]);
    tower_mul = {xx ^ ll, gf16_lambda(hh) ^ ll};
  endfunction

  // tower element that is a root of x^8 + x^4 + x^3 + x + 1
  function automatic logic [7:0] find_root();
    logic [7:0] pw, acc;
    logic found;
    found = 1'b0;
    find_root = 8'h00;
    for (int r = 2; r < 256; r++) begin
      pw  = 8'h01;
      acc = 8'h00;
      for (int e = 0; e <= 8; e++) begin
        if (e == 0 || e == 1 || e == 3 || e == 4 || e == 8) acc ^= pw;
        pw = tower_mul(pw, 8'(r));
      end
      if (acc == 8'h00 && !found) begin
        found = 1'b1;
        find_root = 8'(r);
      end
    end
  endfunction

  function automatic logic [7:0] apply_cols(input logic [7:0][7:0] cols, input logic [7:0] v);
    apply_cols = 8'h00;
    for (int i = 0; i < 8; i++)
      if (v[i]) apply_cols ^= cols[i];
  endfunction

  function automatic logic [7:0][7:0] into_cols();
    logic [7:0] pw, rt;
    rt = find_root();
    pw = 8'h01;
    for (int i = 0; i < 8; i++) begin
      into_cols[i] = pw;
      pw = tower_mul(pw, rt);
    end
  endfunction

  localparam logic [7:0][7:0] INTO_COLS = into_cols();

  function automatic logic [7:0][7:0] back_cols();
    back_cols = '0;
    for (int j = 0; j < 8; j++)
      for (int v = 0; v < 256; v++)
        if (apply_cols(INTO_COLS, 8'(v)) == (8'h01 << j)) back_cols[j] = 8'(v);
  endfunction

  localparam logic [7:0][7:0] BACK_COLS = back_cols();

endpackage

// File: rtl/sbox_affine.sv
module sbox_affine #(
  parameter bit INVERSE = 1'b0
) (
  input  logic [7:0] a_in,
  output logic [7:0] a_out
);
  localparam logic [7:0] FWD_C = 8'h63;
  localparam logic [7:0] INV_C = 8'h05;

  generate
    if (INVERSE) begin : g_inv
      always_comb
        for (int i = 0; i < 8; i++)
          a_out[i] = a_in[(i + 2) % 8] ^ a_in[(i + 5) % 8] ^ a_in[(i + 7) % 8] ^ INV_C[i];
    end else begin : g_fwd
      always_comb
        for (int i = 0; i < 8; i++)
          a_out[i] = a_in[i] ^ a_in[(i + 4) % 8] ^ a_in[(i + 5) % 8]
                   ^ a_in[(i + 6) % 8] ^ a_in[(i + 7) % 8] ^ FWD_C[i];
    end
  endgenerate
endmodule

// File: rtl/sbox_basis_map.sv
module sbox_basis_map #(
  parameter bit TO_TOWER = 1'b1
) (
  input  logic [7:0] m_in,
  output logic [7:0] m_out
);
  import sbox_field_pkg::*;

  localparam logic [7:0][7:0] COLS = TO_TOWER ? INTO_COLS : BACK_COLS;

  always_comb begin
    m_out = 8'h00;
    for (int i = 0; i < 8; i++)
      if (m_in[i]) m_out = m_out ^ COLS[i];
  end
endmodule

// File: rtl/sbox_tower_inverse.sv
module sbox_tower_inverse (
  input  logic [7:0] t_in,
  output logic [7:0] t_out
);
  import sbox_field_pkg::*;

  logic [3:0] hi, lo, delta, delta_inv;

  assign hi = t_in[7:4];
  assign lo = t_in[3:0];

  always_comb begin
    delta     = gf16_lambda(gf16_sq(hi)) ^ gf16_mul(hi, lo) ^ gf16_sq(lo);
    delta_inv = gf16_inv(delta);
    t_out     = {gf16_mul(hi, delta_inv), gf16_mul(hi ^ lo, delta_inv)};
  end
endmodule

// File: rtl/sbox_stage_reg.sv
module sbox_stage_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_d,
  input  logic [W-1:0] dat_d,
  output logic         vld_q,
  output logic [W-1:0] dat_q
);
  logic [W-1:0] dat_n;

  always_comb dat_n = vld_d ? dat_d : dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_n;
    end
  end
endmodule

// File: rtl/shared_sbox_unit.sv
module shared_sbox_unit #(
  parameter bit PIPELINED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_decrypt,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte
);
  localparam int BW = 8;
  localparam int SW = BW + 1;

  logic [BW-1:0] inv_aff, pre_sel, tower_a;
  logic          v1, v2, v3, m1, m2, m3;
  logic [BW-1:0] d1, d2, d3;
  logic [BW-1:0] tower_inv, back, fwd_aff, post_sel;

  // stage A: inverse affine ahead of the inverter in decrypt mode
  sbox_affine #(.INVERSE(1'b1)) u_inv_aff (.a_in(in_byte), .a_out(inv_aff));
  assign pre_sel = in_decrypt ? inv_aff : in_byte;
  sbox_basis_map #(.TO_TOWER(1'b1)) u_into (.m_in(pre_sel), .m_out(tower_a));

  // stage B: shared inverter
  sbox_tower_inverse u_inv (.t_in(d1), .t_out(tower_inv));

  // stage C: back to the AES field, forward affine in encrypt mode
  sbox_basis_map #(.TO_TOWER(1'b0)) u_back (.m_in(d2), .m_out(back));
  sbox_affine #(.INVERSE(1'b0)) u_fwd_aff (.a_in(back), .a_out(fwd_aff));
  assign post_sel = m2 ? back : fwd_aff;

  generate
    if (PIPELINED) begin : g_pipe
      sbox_stage_reg #(.W(SW)) u_r1 (.clk(clk), .rst_n(rst_n), .vld_d(in_valid),
        .dat_d({in_decrypt, tower_a}), .vld_q(v1), .dat_q({m1, d1}));
      sbox_stage_reg #(.W(SW)) u_r2 (.clk(clk), .rst_n(rst_n), .vld_d(v1),
        .dat_d({m1, tower_inv}), .vld_q(v2), .dat_q({m2, d2}));
      sbox_stage_reg #(.W(SW)) u_r3 (.clk(clk), .rst_n(rst_n), .vld_d(v2),
        .dat_d({m2, post_sel}), .vld_q(v3), .dat_q({m3, d3}));
    end else begin : g_comb
      assign {v1, m1, d1} = {in_valid, in_decrypt, tower_a};
      assign {v2, m2, d2} = {v1, m1, tower_inv};
      assign {v3, m3, d3} = {v2, m2, post_sel};
    end
  endgenerate

  assign out_valid = v3;
  assign out_byte  = d3;

  logic unused_mode;
  assign unused_mode = m3;
endmodule

// File: rtl/sbox_unit_checker.sv
module sbox_unit_checker #(
  parameter bit PIPELINED = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_decrypt,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic [7:0] out_byte
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R7
  assert_reset_quiet_R7: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_byte == 8'h00));

  generate
    if (PIPELINED) begin : g_seq
      // R5
      assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst == 2'd3 |-> out_valid == $past(in_valid, 3));
      // R6
      assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !out_valid) |-> $stable(out_byte));
      // R3
      assert_zero_enc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(in_valid && !in_decrypt && in_byte == 8'h00, 3))
        |-> out_byte == 8'h63);
      assert_zero_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(in_valid && in_decrypt && in_byte == 8'h63, 3))
        |-> out_byte == 8'h00);
    end else begin : g_cmb
      // R6
      assert_flow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
      // R3
      assert_zero_enc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_decrypt && in_byte == 8'h00) |-> out_byte == 8'h63);
      assert_zero_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_decrypt && in_byte == 8'h63) |-> out_byte == 8'h00);
      // R1
      assert_enc_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_decrypt && in_byte == 8'h01) |-> out_byte == 8'h7c);
    end
  endgenerate
endmodule

bind shared_sbox_unit sbox_unit_checker #(.PIPELINED(PIPELINED)) u_chk (.*);

// File: tb/shared_sbox_unit_test.sv
module shared_sbox_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_decrypt = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic [7:0] out_byte;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  logic [7:0] sb [256];
  logic [7:0] isb [256];
  logic [7:0] cap [256];
  int cap_n = 0;
  int rt_n = 0;
  int phase = 0;

  // reference pipeline state
  logic       mv0, mv1, ov;
  logic [7:0] md0, md1, od;

  always #2 clk = ~clk;

  shared_sbox_unit uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_decrypt(in_decrypt), .in_byte(in_byte), .out_valid(out_valid),
    .out_byte(out_byte));

  function automatic int gmul(int a, int b);
    int p = 0;
    for (int i = 0; i < 8; i++) begin
      if (b & 1) p ^= a;
      a = a << 1;
      if (a & 256) a ^= 'h11b;
      b = b >> 1;
    end
    return p;
  endfunction

  function automatic int rotl(int v, int n);
    return ((v << n) | (v >> (8 - n))) & 255;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(bit v, bit dec, logic [7:0] b);
    @(negedge clk);
    in_valid = v; in_decrypt = dec; in_byte = b;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv0 <= 0; mv1 <= 0; ov <= 0; md0 <= 0; md1 <= 0; od <= 0;
    end else begin
      mv0 <= in_valid;
      if (in_valid) md0 <= in_decrypt ? isb[in_byte] : sb[in_byte];
      mv1 <= mv0;
      if (mv0) md1 <= md0;
      ov <= mv1;
      if (mv1) od <= md1;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      cycles++;
      check("R1/R2/R5/R6 valid", {7'd0, out_valid}, {7'd0, ov});
      check("R1/R2/R6 data", out_byte, od);
      if (out_valid && phase == 1) begin
        cap[cap_n] = out_byte;
        cap_n++;
      end
      if (out_valid && phase == 2) begin
        check("R4 round trip", out_byte, 8'(rt_n));
        rt_n++;
      end
    end
  end

  initial begin
    for (int x = 0; x < 256; x++) begin
      int inv = 0;
      for (int y = 1; y < 256; y++) if (gmul(x, y) == 1) inv = y;
      sb[x] = 8'(inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 'h63);
    end
    for (int x = 0; x < 256; x++) isb[sb[x]] = 8'(x);

    repeat (3) @(negedge clk);
    check("R7 reset valid", {7'd0, out_valid}, 8'h00);
    check("R7 reset byte", out_byte, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;

    // R1 sweep, captured for R4
    phase = 1;
    for (int x = 0; x < 256; x++) drive(1, 0, 8'(x));
    drive(0, 0, 8'h00);
    repeat (4) @(negedge clk);
    check("R1 capture count", 8'(cap_n == 256), 8'h01);
    check("R1 known 0x53", cap[8'h53], 8'hed);

    // R4: feed results back in decrypt mode
    phase = 2;
    for (int x = 0; x < 256; x++) drive(1, 1, cap[x]);
    drive(0, 0, 8'h00);
    repeat (4) @(negedge clk);
    phase = 0;
    check("R4 count", 8'(rt_n == 256), 8'h01);

    // R2 sweep
    for (int x = 0; x < 256; x++) drive(1, 1, 8'(x));
    // R5/R6 mixed modes with bubbles
    for (int x = 0; x < 200; x++) drive((x % 3) != 2, x[0], 8'(x * 37 + 11));
    drive(0, 0, 8'h00);
    repeat (4) @(negedge clk);

    // R3 and R5 explicit latency, R6 hold
    drive(1, 0, 8'h00);
    drive(0, 1, 8'h63);
    check("R5 not yet 1", {7'd0, out_valid}, 8'h00);
    @(negedge clk);
    check("R5 not yet 2", {7'd0, out_valid}, 8'h00);
    @(negedge clk);
    check("R5 at 3", {7'd0, out_valid}, 8'h01);
    check("R3 enc zero", out_byte, 8'h63);
    @(negedge clk);
    check("R6 hold", out_byte, 8'h63);
    drive(1, 1, 8'h63);
    drive(0, 0, 8'h00);
    repeat (2) @(negedge clk);
    check("R3 dec 0x63", out_byte, 8'h00);
    repeat (3) @(negedge clk);
    check("R6 hold after", out_byte, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule